// File: doc/BRIEF.md
# Pulse-Spreading PWM Channel

This block is one pulse-width modulation channel that counts on a clock already chosen upstream. A frame is a power of two of clock cycles long, with the exponent taken from an encoded resolution field. A duty input gives the number of cycles in each frame during which the output is high. With spreading off, that high time forms a single pulse at the start of the frame. With spreading on, the frame is divided into equal slots, and the high time is shared out across the slots as short pulses. This moves energy to higher frequencies, which makes an external RC filter easier to build.

A 16-bit configuration word holds a local enable, an output invert bit, a 2-bit spreading selector and a 4-bit resolution selector. A master enable input is combined with the local enable, and the channel counts only while both are 1. The resolution, spreading, duty and invert values take effect at frame boundaries, so a frame that has started always finishes with the values it started with.

Top module: `pwm_spread_channel`

## Requirements
- R1: The resolution selector `cfg_word[7:4]` picks N = 7 + value for values 0 to 8. Any value of 9 or higher picks N = 16.
- R2: While the channel runs, the frame counter steps by one each clock from 0 to 2^N − 1 and then returns to 0, so the frame is 2^N clocks long.
- R3: The channel runs only when the local enable `cfg_word[0]` and `master_en` are both 1. When it is not running, the counter is held at 0 and `pwm_out` equals the invert bit `cfg_word[1]`.
- R4: When the invert bit latched for the frame is 1, `pwm_out` is the complement of the normal waveform.
- R5: The spreading selector `cfg_word[3:2]` with value s sets the number of slots to 2^N / 2^(10−s), with a minimum of one slot. Each slot is 2^N / slots clocks long.
- R6: With M slots and duty D < 2^N, every slot begins with floor(D/M) high clocks. Each of the first (D mod M) slots has one extra high clock, and the rest of each slot is low.
- R7: When the frame is a single slot, the output is one pulse of D clocks at the start of the frame.
- R8: Duty, resolution, spreading and invert are sampled only at a frame boundary, or while the channel is not running. A change made mid-frame first shows up in the next frame.
- R9: A duty of 0 gives a constant low level, and a duty of 2^N or more gives a constant high level. Both levels are taken before the inversion stage.
- R10: After reset with an all-zero configuration word, `pwm_out` is 0 and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected PWM counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Master enable, ANDed with the local enable |
| cfg_word | input | 16 | Bit 0 local enable, bit 1 invert, bits 3:2 spreading, bits 7:4 resolution, bits 15:8 ignored |
| duty | input | 17 | High clocks per frame, range 0 to 2^16 |
| pwm_out | output | 1 | PWM output after inversion |

## Verification
The checker watches several properties on every clock cycle:
- The counter steps by one and wraps only at the last count of the frame.
- The counter sits at zero, and the output sits at the idle invert level, while the channel is not running.
- The latched duty and frame length stay fixed inside a frame.
- Duties of 0 and of at least 2^N give constant output levels.

The shape of the spread waveform can only be shown by the bench scenarios. Those scenarios check the slot count and slot length for each resolution and spreading setting, and where the remainder high clocks are placed. They also check the total high time, the restart from position 0 after the channel is disabled, and a duty change made mid-frame that appears only in the next frame.

// File: rtl/pwm_spread_pkg.sv
// Shared types for the pulse-spreading PWM channel.
// Assumes the configuration word carries its fields in bits 7:0.
package pwm_spread_pkg;
    localparam int EXP_W = 5;

    // Field layout of cfg_word[7:0], with the MSB first.
    typedef struct packed {
        logic [3:0] res_sel;
        logic [1:0] spread_sel;
        logic       invert;
        logic       enable;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_res_decode.sv
// Turns the resolution and spreading selectors into exponents:
// res_bits = log2(frame length), slot_exp = log2(slot count).
// Assumes MAX_RES - MIN_RES fits in the 4-bit selector.
module pwm_res_decode
    import pwm_spread_pkg::*;
#(
    parameter int MIN_RES     = 7,
    parameter int MAX_RES     = 16,
    parameter int SPREAD_BASE = 10
) (
    input  logic [3:0]       res_sel,
    input  logic [1:0]       spread_sel,
    output logic [EXP_W-1:0] res_bits,
    output logic [EXP_W-1:0] slot_exp
);
    localparam int RES_SPAN = MAX_RES - MIN_RES;

    logic [EXP_W-1:0] div_exp;

    // Clamp the resolution and derive the slot exponent, never below zero.
    always_comb begin
        if (res_sel >= 4'(RES_SPAN))
            res_bits = EXP_W'(MAX_RES);
        else
            res_bits = EXP_W'(res_sel) + EXP_W'(MIN_RES);
        div_exp  = EXP_W'(SPREAD_BASE) - EXP_W'(spread_sel);
        slot_exp = (res_bits > div_exp) ? (res_bits - div_exp) : '0;
    end
endmodule

// File: rtl/pwm_frame_counter.sv
// Frame position counter. It runs from 0 to frame_last and wraps to 0.
// It is held at 0 while run is low. The load output marks the cycles in which
// the parent may take new shadow values.
module pwm_frame_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] frame_last,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);
    assign load = !run || (cnt == frame_last);

    // Advance the position, or restart it at a boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_spread_compare.sv
// Raw (non-inverted) level for the current frame position.
// Each slot opens with floor(duty/slots) high clocks.
// The first (duty mod slots) slots get one extra high clock.
// Assumes slot_exp <= res_bits and res_bits < DUTY_W.
module pwm_spread_compare #(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 17,
    parameter int EXP_W  = 5
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [EXP_W-1:0]  res_bits,
    input  logic [EXP_W-1:0]  slot_exp,
    input  logic [DUTY_W-1:0] duty,
    output logic              level
);
    logic [EXP_W-1:0]  seg_bits;
    logic [DUTY_W-1:0] frame_len, pos, slot_idx, base, rem;
    logic              extra;

    // Split the position into slot index and offset, then compare.
    always_comb begin
        seg_bits  = res_bits - slot_exp;
        frame_len = DUTY_W'(1) << res_bits;
        pos       = DUTY_W'(cnt) & ((DUTY_W'(1) << seg_bits) - DUTY_W'(1));
        slot_idx  = DUTY_W'(cnt) >> seg_bits;
        base      = duty >> slot_exp;
        rem       = duty & ((DUTY_W'(1) << slot_exp) - DUTY_W'(1));
        extra     = slot_idx < rem;
        level     = (duty >= frame_len) || (pos < (base + DUTY_W'(extra)));
    end
endmodule

// File: rtl/pwm_spread_channel.sv
// Top of the pulse-spreading PWM channel. It latches the decoded configuration
// and the duty at frame boundaries, counts frame positions and drives the
// output through the inversion stage.
// Assumes clk is the chosen PWM clock and that cfg_word bits 15:8 are unused.
module pwm_spread_channel
    import pwm_spread_pkg::*;
#(
    parameter int MIN_RES     = 7,
    parameter int MAX_RES     = 16,
    parameter int SPREAD_BASE = 10,
    parameter int CFG_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [MAX_RES:0]  duty,
    output logic              pwm_out
);
    localparam int CNT_W  = MAX_RES;
    localparam int DUTY_W = MAX_RES + 1;

    chan_cfg_t        cfg;
    logic             unused_cfg_hi;
    logic             run, load, level;
    logic [EXP_W-1:0] res_d, slot_d, res_q, slot_q;
    logic [DUTY_W-1:0] duty_q;
    logic             inv_q;
    logic [CNT_W-1:0] cnt, frame_last;

    assign cfg           = chan_cfg_t'(cfg_word[7:0]);
    assign unused_cfg_hi = ^cfg_word[CFG_W-1:8];
    assign run           = cfg.enable & master_en;

    pwm_res_decode #(
        .MIN_RES(MIN_RES), .MAX_RES(MAX_RES), .SPREAD_BASE(SPREAD_BASE)
    ) i_decode (
        .res_sel(cfg.res_sel), .spread_sel(cfg.spread_sel),
        .res_bits(res_d), .slot_exp(slot_d)
    );

    // Shadow copies used for the whole frame, refreshed only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= EXP_W'(MIN_RES);
            slot_q <= '0;
            duty_q <= '0;
            inv_q  <= 1'b0;
        end else if (load) begin
            res_q  <= res_d;
            slot_q <= slot_d;
            duty_q <= duty;
            inv_q  <= cfg.invert;
        end
    end

    assign frame_last = CNT_W'((DUTY_W'(1) << res_q) - DUTY_W'(1));

    pwm_frame_counter #(.CNT_W(CNT_W)) i_counter (
        .clk(clk), .rst_n(rst_n), .run(run),
        .frame_last(frame_last), .cnt(cnt), .load(load)
    );

    pwm_spread_compare #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .EXP_W(EXP_W)) i_compare (
        .cnt(cnt), .res_bits(res_q), .slot_exp(slot_q),
        .duty(duty_q), .level(level)
    );

    // Output stage: the live idle level while stopped, the inverted latched level while running.
    always_comb begin
        if (run)
            pwm_out = level ^ inv_q;
        else
            pwm_out = cfg.invert;
    end
endmodule

// File: rtl/pwm_spread_channel_chk.sv
// Assertion checker bound into pwm_spread_channel. It watches the counter,
// the shadow registers and the output.
module pwm_spread_channel_chk #(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  frame_last,
    input logic [DUTY_W-1:0] duty_s,
    input logic              inv_s,
    input logic              cfg_inv,
    input logic              pwm_out
);
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pwm_out == cfg_inv);

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != frame_last) |=> cnt == $past(cnt) + 1'b1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == frame_last) |=> cnt == '0);

    p_min_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last >= CNT_W'(127));

    p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0 |-> ($stable(duty_s) && $stable(frame_last) && $stable(inv_s)));

    p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_s == '0) |-> pwm_out == inv_s);

    p_full_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_s > DUTY_W'(frame_last)) |-> pwm_out != inv_s);
endmodule

bind pwm_spread_channel pwm_spread_channel_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .frame_last(frame_last),
    .duty_s(duty_q), .inv_s(inv_q), .cfg_inv(cfg.invert), .pwm_out(pwm_out)
);

// File: tb/test_pwm_spread_channel.sv
`timescale 1ns/1ps
module test_pwm_spread_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [16:0] duty = '0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_spread_channel i_pwm_spread_channel (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .cfg_word(cfg_word), .duty(duty), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [3:0]  res;
        logic [1:0]  sp;
        logic        inv;
        logic [16:0] dty;
        logic [16:0] flen;
        logic [16:0] high;
    } vec_t;

    // Each row: res selector, spread selector, invert, duty, expected frame length, expected high clocks.
    localparam vec_t VEC [10] = '{
        '{4'd0,  2'd0, 1'b0, 17'd40,   17'd128,   17'd40},
        '{4'd0,  2'd0, 1'b1, 17'd40,   17'd128,   17'd88},
        '{4'd1,  2'd3, 1'b0, 17'd101,  17'd256,   17'd101},
        '{4'd2,  2'd3, 1'b0, 17'd300,  17'd512,   17'd300},
        '{4'd3,  2'd2, 1'b0, 17'd5,    17'd1024,  17'd5},
        '{4'd0,  2'd0, 1'b0, 17'd0,    17'd128,   17'd0},
        '{4'd0,  2'd0, 1'b0, 17'd200,  17'd128,   17'd128},
        '{4'd2,  2'd0, 1'b0, 17'd511,  17'd512,   17'd511},
        '{4'd1,  2'd0, 1'b0, 17'd101,  17'd256,   17'd101},
        '{4'd15, 2'd3, 1'b0, 17'd1000, 17'd65536, 17'd1000}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Expected raw level at position k, following R1, R5, R6, R7 and R9.
    function automatic bit model(input int res, input int sp, input int d, input int k);
        int n      = (res >= 9) ? 16 : res + 7;
        int dexp   = 10 - sp;
        int s      = (n > dexp) ? n - dexp : 0;
        int seg    = n - s;
        int pos    = k % (1 << seg);
        int slot   = k >> seg;
        int base_h = d >> s;
        int rem    = d % (1 << s);
        if (d >= (1 << n)) return 1'b1;
        return pos < base_h + ((slot < rem) ? 1 : 0);
    endfunction

    // Configure the channel while the master enable is low, then start it at position 0.
    task automatic start(input int res, input int sp, input bit inv, input int d);
        @(negedge clk);
        master_en = 1'b0;
        cfg_word  = {8'h00, 4'(res), 2'(sp), inv, 1'b1};
        duty      = 17'(d);
        repeat (2) @(negedge clk);
        master_en = 1'b1;
        #1;
    endtask

    // Compare positions first..last against the model. Returns mismatches and raw high clocks.
    task automatic walk(input int res, input int sp, input bit inv, input int d,
                        input int first, input int last, output int bad, output int hi);
        bad = 0;
        hi  = 0;
        for (int k = first; k <= last; k++) begin
            if (pwm_out !== (model(res, sp, d, k) ^ inv)) bad++;
            if ((pwm_out ^ inv) === 1'b1) hi++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int bad, hi;
        // R10: idle output during and after reset.
        repeat (3) @(negedge clk);
        check(pwm_out === 1'b0, "R10 in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out === 1'b0, "R10 after reset", int'(pwm_out), 0);

        // Table of frames: shape (R5 R6 R7 R4), total high time (R2 R9), wrap to position 0 (R1 R2).
        for (int i = 0; i < 10; i++) begin
            start(VEC[i].res, VEC[i].sp, VEC[i].inv, VEC[i].dty);
            walk(VEC[i].res, VEC[i].sp, VEC[i].inv, VEC[i].dty, 0, VEC[i].flen - 1, bad, hi);
            check(bad == 0, "R6 R7 R4 frame shape", bad, 0);
            check(hi == int'(VEC[i].inv ? VEC[i].flen - VEC[i].high : VEC[i].high),
                  "R2 R9 high clocks", hi, int'(VEC[i].high));
            check(pwm_out === (model(VEC[i].res, VEC[i].sp, VEC[i].dty, 0) ^ VEC[i].inv),
                  "R1 R2 wrap to position 0", int'(pwm_out),
                  int'(model(VEC[i].res, VEC[i].sp, VEC[i].dty, 0) ^ VEC[i].inv));
        end

        // R3: master enable low, local enable high, invert 1: output held at 1.
        @(negedge clk);
        master_en = 1'b0;
        cfg_word  = 16'h0003;
        duty      = 17'd64;
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (pwm_out !== 1'b1) bad++;
        end
        check(bad == 0, "R3 master off idle inverted", bad, 0);

        // R3: local enable low, master high, invert 0: output held at 0.
        cfg_word  = 16'h0000;
        master_en = 1'b1;
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (pwm_out !== 1'b0) bad++;
        end
        check(bad == 0, "R3 local off idle low", bad, 0);

        // R3: disabling mid-frame restarts the frame at position 0.
        start(0, 0, 1'b0, 40);
        repeat (60) @(negedge clk);
        #1;
        check(pwm_out === 1'b0, "R3 position 60 low", int'(pwm_out), 0);
        master_en = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        #1;
        check(pwm_out === 1'b1, "R3 restart at position 0", int'(pwm_out), 1);
        repeat (40) @(negedge clk);
        #1;
        check(pwm_out === 1'b0, "R3 restarted position 40 low", int'(pwm_out), 0);

        // R8: a mid-frame change of duty and resolution waits for the frame boundary.
        start(0, 0, 1'b0, 40);
        walk(0, 0, 1'b0, 40, 0, 9, bad, hi);
        cfg_word = {8'h00, 4'd1, 2'd0, 1'b0, 1'b1};
        duty     = 17'd100;
        #1;
        walk(0, 0, 1'b0, 40, 10, 127, bad, hi);
        check(bad == 0, "R8 current frame keeps old values", bad, 0);
        check(hi == 30, "R8 old duty high count", hi, 30);
        walk(1, 0, 1'b0, 100, 0, 255, bad, hi);
        check(bad == 0 && hi == 100, "R8 next frame uses new values", hi, 100);

        master_en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule